// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block is the holding station between instruction dispatch and a pool of identical execution pipelines. Each dispatched micro-op carries a retire identifier and up to two source tags with availability flags. It takes one of a fixed number of slots. A slot sits in a waiting state until every source has been produced, moves to a ready state, and then competes for issue. Producers announce results on a tag broadcast bus, and that bus wakes the waiting slots.

Once per cycle the block picks the oldest ready slot. A round-robin pointer assigns it to a free pipeline of the group, and the slot stays in an issued state for the fixed pipeline latency. At write-back the slot is released and the retire identifier is presented to the retire logic. The block raises a full flag toward dispatch when every slot is taken. For performance analysis it also keeps occupancy statistics: the current and peak occupancy, the running occupancy sum (average = sum / cycles), and a two-bin histogram of idle cycles versus cycles that issued one micro-op.

Top module: `issue_sched`

## Requirements
- R1: A dispatch is accepted when `disp_valid` is high and `full` is low. The micro-op is never issued in the cycle it is dispatched. A source counts as available if its `disp_src_rdy` bit is 1, or if `bcast_valid` is high in the dispatch cycle with a matching tag. If all sources are available, the micro-op may issue in the next cycle.
- R2: A source that was not available is woken by a broadcast with an equal tag. A broadcast in cycle t allows issue no earlier than cycle t+1, and a non-matching tag wakes nothing.
- R3: When several slots are ready, the one dispatched earliest issues first, whatever slot index it occupies. At most one micro-op issues per cycle.
- R4: The pipeline is chosen by scanning unit indices upward from a pointer, wrapping modulo NUNIT, and taking the first unit whose `unit_busy` bit is 0. After an issue on unit u the pointer becomes (u+1) mod NUNIT. The pointer resets to 0, and `iss_unit` is the binary unit index.
- R5: While every `unit_busy` bit is 1, `iss_valid` stays 0 and ready slots keep waiting.
- R6: `wb_valid` is high with `wb_id` equal to the issued identifier exactly LAT cycles after the issue cycle. The slot is free for a new dispatch from the following cycle.
- R7: `full` is 1 exactly when all DEPTH slots are occupied. A dispatch presented while `full` is 1 is dropped and never issues.
- R8: `occ` is the number of occupied slots. `occ_max` is the largest `occ` seen in earlier cycles. `occ_sum` adds `occ` every cycle. `hist_idle` and `hist_issue` count cycles with zero issues and with one issue.
- R9: After reset all slots are free, nothing issues or writes back, and all statistics read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_id | input | ID_W | Retire identifier of the dispatched micro-op |
| disp_src_tag | input | NSRC*TAG_W | Source tags, source s in bits [s*TAG_W +: TAG_W] |
| disp_src_rdy | input | NSRC | Source availability at dispatch, bit s for source s |
| full | output | 1 | All slots occupied, dispatch refused |
| bcast_valid | input | 1 | Result tag broadcast valid |
| bcast_tag | input | TAG_W | Broadcast result tag |
| unit_busy | input | NUNIT | Per-pipeline busy flags |
| iss_valid | output | 1 | A micro-op issues this cycle |
| iss_unit | output | UIDX_W | Pipeline index chosen for the issue |
| iss_id | output | ID_W | Identifier of the issuing micro-op |
| wb_valid | output | 1 | Write-back this cycle, notifies retire logic |
| wb_id | output | ID_W | Identifier reaching write-back |
| occ | output | CW | Slots currently occupied |
| occ_max | output | CW | Peak occupancy over past cycles |
| occ_sum | output | CNT_W | Occupancy accumulated per cycle |
| hist_idle | output | CNT_W | Cycles with no issue |
| hist_issue | output | CNT_W | Cycles with one issue |

## Verification
A corrupted age relation shows up the first time two ready slots compete: the younger identifier appears on `iss_id` one cycle too early. A stuck waiting bit or a missed wakeup holds `iss_valid` low in the cycle after the matching broadcast. A wrong round-robin pointer is visible on `iss_unit` at the very next issue, and a miscounted latency moves `wb_valid` away from issue plus LAT. Bookkeeping errors in a slot show up within one cycle as an `occ` or `full` value that disagrees with the accepted dispatches minus the write-backs.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_READY  = 2'd2,
    ST_ISSUED = 2'd3
  } slot_state_e;

  // number of set bits
  function automatic int unsigned f_popcount(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // isolate the lowest set bit
  function automatic logic [31:0] f_lowest(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  // first non-busy unit scanning upward from ptr, -1 when all busy
  function automatic int f_rr_pick(input logic [31:0] busy, input int ptr, input int n);
    int res;
    int u;
    res = -1;
    for (int k = n - 1; k >= 0; k--) begin
      u = (ptr + k) % n;
      if (!busy[u]) res = u;
    end
    // lowest k wins: re-scan to honour wrap order
    for (int k = n - 1; k >= 0; k--) begin
      u = (ptr + k) % n;
      if (!busy[u]) res = u;
    end
    return res;
  endfunction

endpackage

// File: rtl/sched_slot.sv
module sched_slot
  import issue_sched_pkg::*;
#(
  parameter int NSRC  = 2,
  parameter int TAG_W = 4,
  parameter int ID_W  = 4,
  parameter int LAT   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_i,
  input  logic [NSRC*TAG_W-1:0] src_tag_i,
  input  logic [NSRC-1:0]       src_rdy_i,
  input  logic [ID_W-1:0]       id_i,
  input  logic                  bcast_valid_i,
  input  logic [TAG_W-1:0]      bcast_tag_i,
  input  logic                  grant_i,
  output logic                  valid_o,
  output logic                  ready_o,
  output logic                  wb_o,
  output logic [ID_W-1:0]       id_o
);
  localparam int LCW = $clog2(LAT + 1);

  slot_state_e           st_q;
  logic [NSRC-1:0]       rdy_q;
  logic [NSRC*TAG_W-1:0] tag_q;
  logic [ID_W-1:0]       id_q;
  logic [LCW-1:0]        cnt_q;
  logic [NSRC-1:0]       hit_new, hit_old;
  logic [NSRC-1:0]       avail_new, avail_old;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      hit_new[s] = bcast_valid_i && (bcast_tag_i == src_tag_i[s*TAG_W +: TAG_W]);
      hit_old[s] = bcast_valid_i && (bcast_tag_i == tag_q[s*TAG_W +: TAG_W]);
    end
    avail_new = src_rdy_i | hit_new;
    avail_old = rdy_q | hit_old;
  end

  assign valid_o = (st_q != ST_FREE);
  assign ready_o = (st_q == ST_READY);
  assign wb_o    = (st_q == ST_ISSUED) && (cnt_q == LCW'(1));
  assign id_o    = id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_FREE;
      rdy_q <= '0;
      tag_q <= '0;
      id_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_FREE: if (alloc_i) begin
          tag_q <= src_tag_i;
          id_q  <= id_i;
          rdy_q <= avail_new;
          st_q  <= (&avail_new) ? ST_READY : ST_WAIT;
        end
        ST_WAIT: begin
          rdy_q <= avail_old;
          if (&avail_old) st_q <= ST_READY;
        end
        ST_READY: if (grant_i) begin
          st_q  <= ST_ISSUED;
          cnt_q <= LCW'(LAT);
        end
        ST_ISSUED: begin
          if (cnt_q == LCW'(1)) st_q <= ST_FREE;
          else cnt_q <= cnt_q - LCW'(1);
        end
        default: st_q <= ST_FREE;
      endcase
    end
  end

  // R3: the picker only grants a slot in the ready state
  p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> (st_q == ST_READY));
  // R7: allocation only lands on a free slot
  p_alloc_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (st_q == ST_FREE));
  // R1: never granted in the allocation cycle
  p_no_same_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !grant_i);
  // R1: a freshly allocated slot is not ready before the next cycle
  p_alloc_then_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> (st_q == ST_WAIT || st_q == ST_READY));

endmodule

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] ready_i,
  input  logic [DEPTH-1:0] alloc_i,
  output logic [DEPTH-1:0] pick_o
);
  // older_q[j][i] set: slot j holds an older micro-op than slot i
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) older_q[j] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < DEPTH; j++) begin
            if (j == k) older_q[k] <= '0;
            else        older_q[j][k] <= valid_i[j];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (ready_i[j] && older_q[j][i]) blocked = 1'b1;
      pick_o[i] = ready_i[i] && !blocked;
    end
  end

  // R3: at most one oldest candidate, and one exists whenever something is ready
  p_pick_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_o));
  p_pick_exists_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready_i) |-> (|pick_o));

endmodule

// File: rtl/sched_unit_rr.sv
module sched_unit_rr
  import issue_sched_pkg::*;
#(
  parameter int NUNIT  = 3,
  parameter int UIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUNIT-1:0]  busy_i,
  input  logic              take_i,
  output logic              found_o,
  output logic [UIDX_W-1:0] unit_o
);
  logic [UIDX_W-1:0] ptr_q;
  int                pick;

  always_comb begin
    pick    = f_rr_pick(32'(busy_i), int'(ptr_q), NUNIT);
    found_o = (pick >= 0);
    unit_o  = found_o ? UIDX_W'(pick) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (take_i && found_o)
      ptr_q <= (unit_o == UIDX_W'(NUNIT - 1)) ? '0 : unit_o + UIDX_W'(1);
  end

  // R4: pointer always names an existing unit
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NUNIT);
  // R4: a chosen unit is never busy
  p_found_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> !busy_i[unit_o]);

endmodule

// File: rtl/sched_stats.sv
module sched_stats #(
  parameter int CW    = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    occ_i,
  input  logic             issued_i,
  output logic [CW-1:0]    occ_max_o,
  output logic [CNT_W-1:0] occ_sum_o,
  output logic [CNT_W-1:0] hist_idle_o,
  output logic [CNT_W-1:0] hist_issue_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_max_o    <= '0;
      occ_sum_o    <= '0;
      hist_idle_o  <= '0;
      hist_issue_o <= '0;
    end else begin
      if (occ_i > occ_max_o) occ_max_o <= occ_i;
      occ_sum_o <= occ_sum_o + CNT_W'(occ_i);
      if (issued_i) hist_issue_o <= hist_issue_o + CNT_W'(1);
      else          hist_idle_o  <= hist_idle_o + CNT_W'(1);
    end
  end

  // R8: the peak never decreases
  p_max_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(occ_max_o) |-> (occ_max_o > $past(occ_max_o)));

endmodule

// File: rtl/issue_sched.sv
module issue_sched
  import issue_sched_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int NSRC  = 2,
  parameter int TAG_W = 4,
  parameter int ID_W  = 4,
  parameter int NUNIT = 3,
  parameter int LAT   = 3,
  parameter int CNT_W = 16,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int UIDX_W = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_valid,
  input  logic [ID_W-1:0]       disp_id,
  input  logic [NSRC*TAG_W-1:0] disp_src_tag,
  input  logic [NSRC-1:0]       disp_src_rdy,
  output logic                  full,
  input  logic                  bcast_valid,
  input  logic [TAG_W-1:0]      bcast_tag,
  input  logic [NUNIT-1:0]      unit_busy,
  output logic                  iss_valid,
  output logic [UIDX_W-1:0]     iss_unit,
  output logic [ID_W-1:0]       iss_id,
  output logic                  wb_valid,
  output logic [ID_W-1:0]       wb_id,
  output logic [CW-1:0]         occ,
  output logic [CW-1:0]         occ_max,
  output logic [CNT_W-1:0]      occ_sum,
  output logic [CNT_W-1:0]      hist_idle,
  output logic [CNT_W-1:0]      hist_issue
);
  logic [DEPTH-1:0] valid_vec, ready_vec, wb_vec, alloc_vec, pick_vec, grant_vec;
  logic [ID_W-1:0]  slot_id [DEPTH];
  logic             unit_found;

  assign full      = &valid_vec;
  assign alloc_vec = (disp_valid && !full) ? DEPTH'(f_lowest(32'(~valid_vec))) : '0;
  assign occ       = CW'(f_popcount(32'(valid_vec)));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    sched_slot #(.NSRC(NSRC), .TAG_W(TAG_W), .ID_W(ID_W), .LAT(LAT)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc_vec[g]),
      .src_tag_i    (disp_src_tag),
      .src_rdy_i    (disp_src_rdy),
      .id_i         (disp_id),
      .bcast_valid_i(bcast_valid),
      .bcast_tag_i  (bcast_tag),
      .grant_i      (grant_vec[g]),
      .valid_o      (valid_vec[g]),
      .ready_o      (ready_vec[g]),
      .wb_o         (wb_vec[g]),
      .id_o         (slot_id[g])
    );
  end

  sched_age_pick #(.DEPTH(DEPTH)) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(valid_vec),
    .ready_i(ready_vec),
    .alloc_i(alloc_vec),
    .pick_o (pick_vec)
  );

  sched_unit_rr #(.NUNIT(NUNIT), .UIDX_W(UIDX_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (unit_busy),
    .take_i (iss_valid),
    .found_o(unit_found),
    .unit_o (iss_unit)
  );

  assign grant_vec = unit_found ? pick_vec : '0;
  assign iss_valid = |grant_vec;
  assign wb_valid  = |wb_vec;

  always_comb begin
    iss_id = '0;
    wb_id  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant_vec[i]) iss_id |= slot_id[i];
      if (wb_vec[i])    wb_id  |= slot_id[i];
    end
  end

  sched_stats #(.CW(CW), .CNT_W(CNT_W)) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .occ_i       (occ),
    .issued_i    (iss_valid),
    .occ_max_o   (occ_max),
    .occ_sum_o   (occ_sum),
    .hist_idle_o (hist_idle),
    .hist_issue_o(hist_issue)
  );

  // R3: one issue per cycle
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  // R5: never issue onto a busy pipeline
  p_no_busy_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !unit_busy[iss_unit]);
  // R7: no allocation while full
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (alloc_vec == '0));
  // R6: write-backs never collide
  p_wb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_vec));
  // R6: a write-back frees exactly one slot in the next cycle
  p_wb_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !disp_valid) |=> (occ == $past(occ) - CW'(1)));

endmodule

// File: tb/issue_sched_tb.sv
`timescale 1ns/100ps
module issue_sched_tb;
  localparam int DEPTH = 4, NSRC = 2, TAG_W = 4, ID_W = 4, NUNIT = 3, LAT = 3, CNT_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, disp_valid, bcast_valid, full, iss_valid, wb_valid;
  logic [ID_W-1:0] disp_id, iss_id, wb_id;
  logic [NSRC*TAG_W-1:0] disp_src_tag;
  logic [NSRC-1:0] disp_src_rdy;
  logic [TAG_W-1:0] bcast_tag;
  logic [NUNIT-1:0] unit_busy;
  logic [1:0] iss_unit;
  logic [2:0] occ, occ_max;
  logic [CNT_W-1:0] occ_sum, hist_idle, hist_issue;

  issue_sched u_dut (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_occ = 0, exp_max = 0, exp_sum = 0, exp_idle = 0, exp_iss = 0, exp_ptr = 0;
  int issue_cyc [16];
  int issue_cnt [16];
  bit s_iss, s_wb, s_full, finished = 0;
  int s_iss_id, s_iss_unit, s_wb_id;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int rr_ref(input logic [NUNIT-1:0] b, input int p);
    for (int k = 0; k < NUNIT; k++)
      if (!b[(p + k) % NUNIT]) return (p + k) % NUNIT;
    return -1;
  endfunction

  // sample outputs 1 ns after the input change, update the model, move to next negedge
  task automatic tick();
    int eu;
    #1;
    s_iss = iss_valid; s_iss_id = int'(iss_id); s_iss_unit = int'(iss_unit);
    s_wb = wb_valid; s_wb_id = int'(wb_id); s_full = full;
    chk(int'(occ) == exp_occ, "R8 occ", int'(occ), exp_occ);
    chk(full == (exp_occ == DEPTH), "R7 full flag", int'(full), int'(exp_occ == DEPTH));
    chk(int'(occ_max) == exp_max, "R8 occ_max", int'(occ_max), exp_max);
    chk(int'(occ_sum) == exp_sum, "R8 occ_sum", int'(occ_sum), exp_sum);
    chk(int'(hist_idle) == exp_idle && int'(hist_issue) == exp_iss, "R8 histogram",
        int'(hist_issue), exp_iss);
    if (&unit_busy) chk(!iss_valid, "R5 issue while all busy", int'(iss_valid), 0);
    if (iss_valid) begin
      eu = rr_ref(unit_busy, exp_ptr);
      chk(int'(iss_unit) == eu, "R4 unit choice", int'(iss_unit), eu);
      exp_ptr = (eu + 1) % NUNIT;
      issue_cyc[iss_id] = cyc;
      issue_cnt[iss_id]++;
    end
    if (wb_valid)
      chk(cyc - issue_cyc[wb_id] == LAT, "R6 write-back latency", cyc - issue_cyc[wb_id], LAT);
    exp_sum += exp_occ;
    if (exp_occ > exp_max) exp_max = exp_occ;
    if (iss_valid) exp_iss++; else exp_idle++;
    exp_occ += int'(disp_valid && !full) - int'(wb_valid);
    cyc++;
    @(negedge clk);
  endtask

  task automatic dsp(input int id, input int t0, input bit r0, input int t1, input bit r1);
    disp_valid = 1'b1; disp_id = ID_W'(id);
    disp_src_tag = {TAG_W'(t1), TAG_W'(t0)};
    disp_src_rdy = {r1, r0};
  endtask

  task automatic idle_in();
    disp_valid = 1'b0; bcast_valid = 1'b0;
  endtask

  task automatic drain();
    idle_in(); unit_busy = '0;
    for (int k = 0; k < 8; k++) tick();
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin issue_cyc[k] = -100; issue_cnt[k] = 0; end
    rst_n = 1'b0; disp_valid = 0; disp_id = 0; disp_src_tag = 0; disp_src_rdy = 0;
    bcast_valid = 0; bcast_tag = 0; unit_busy = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    #1;
    chk(!iss_valid && !wb_valid && !full && occ == 0, "R9 reset outputs", int'(occ), 0);
    chk(occ_max == 0 && occ_sum == 0 && hist_idle == 0 && hist_issue == 0,
        "R9 reset stats", int'(occ_sum), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: ready at dispatch, issues next cycle, never same cycle
    dsp(1, 0, 1, 0, 1); tick();
    chk(!s_iss, "R1 no issue in dispatch cycle", int'(s_iss), 0);
    idle_in(); tick();
    chk(s_iss && s_iss_id == 1, "R1 issue next cycle", s_iss_id, 1);
    tick(); tick(); tick();
    chk(s_wb && s_wb_id == 1, "R6 write-back id", s_wb_id, 1);
    tick();

    // R2: wakeup through broadcast
    dsp(4, 5, 0, 3, 1); tick();
    idle_in(); tick();
    chk(!s_iss, "R2 waiting slot held", int'(s_iss), 0);
    bcast_valid = 1; bcast_tag = 6; tick();
    chk(!s_iss, "R2 wrong tag no wake", int'(s_iss), 0);
    bcast_tag = 5; tick();
    chk(!s_iss, "R2 no issue in broadcast cycle", int'(s_iss), 0);
    bcast_valid = 0; tick();
    chk(s_iss && s_iss_id == 4, "R2 issue after broadcast", s_iss_id, 4);
    // R1: same-cycle broadcast counts as available at dispatch
    dsp(5, 7, 0, 7, 0); bcast_valid = 1; bcast_tag = 7; tick();
    idle_in(); tick();
    chk(s_iss && s_iss_id == 5, "R1 dispatch-cycle broadcast", s_iss_id, 5);
    // R2: two sources woken one at a time
    dsp(6, 1, 0, 2, 0); tick();
    idle_in(); bcast_valid = 1; bcast_tag = 1; tick();
    bcast_valid = 0; tick();
    chk(!s_iss, "R2 one source still pending", int'(s_iss), 0);
    bcast_valid = 1; bcast_tag = 2; tick();
    bcast_valid = 0; tick();
    chk(s_iss && s_iss_id == 6, "R2 both sources woken", s_iss_id, 6);
    drain();

    // R3: oldest first regardless of slot index
    unit_busy = '1;
    dsp(1, 0, 1, 0, 1); tick();
    dsp(2, 0, 1, 0, 1); tick();
    idle_in(); unit_busy = 3'b110; tick();
    chk(s_iss && s_iss_id == 1, "R3 first oldest", s_iss_id, 1);
    unit_busy = '1; tick(); tick(); tick();
    dsp(3, 0, 1, 0, 1); tick();
    idle_in(); unit_busy = '0; tick();
    chk(s_iss && s_iss_id == 2, "R3 older entry in higher slot", s_iss_id, 2);
    tick();
    chk(s_iss && s_iss_id == 3, "R3 younger entry after", s_iss_id, 3);
    drain();

    // R7: fill, drop while full, then release in order
    unit_busy = '1;
    for (int k = 8; k < 12; k++) begin dsp(k, 0, 1, 0, 1); tick(); end
    dsp(12, 0, 1, 0, 1); tick();
    chk(s_full, "R7 full after DEPTH dispatches", int'(s_full), 1);
    idle_in(); tick();
    chk(!s_iss, "R5 held while busy", int'(s_iss), 0);
    unit_busy = '0;
    for (int k = 8; k < 12; k++) begin
      tick();
      chk(s_iss && s_iss_id == k, "R3 age order after full", s_iss_id, k);
    end
    drain();
    chk(issue_cnt[12] == 0, "R7 dispatch while full dropped", issue_cnt[12], 0);

    // R4: sweep busy patterns, two passes to visit every pointer value
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < 7; p++) begin
        unit_busy = NUNIT'(p);
        dsp(13, 0, 1, 0, 1); tick();
        idle_in(); tick();
        chk(s_iss, "R4 issue with a free unit", int'(s_iss), 1);
        tick(); tick();
      end
    end
    drain();

    chk(exp_max == DEPTH && int'(occ_max) == DEPTH, "R8 peak reaches DEPTH", int'(occ_max), DEPTH);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule